// File: doc/BRIEF.md
# Saturating Up/Down Hex Counter

This block keeps a single hexadecimal digit, from 0 to 15, and steps it once per rate tick in a direction chosen by one button press. An up press starts the digit climbing and a down press starts it falling. Either run continues on its own and halts at the end of the range, F or 0. A load press copies the low four bits of a switch bus into the digit. It overrides anything else pressed in the same cycle and leaves the machine idle. The value is presented as a 4-bit count and as an active-low seven-segment pattern for one digit.

The buttons arrive already debounced and are level signals. Inside the block, each one passes through a rising-edge detector, so a key held for any length of time is taken as one command. The rate tick is a one-cycle enable pulse from an external divider. In use it arrives every half second, but any spacing works. All inputs and outputs are plain control and status pins. There is no stream interface and no back-pressure.

Top module: `updown_hex_counter`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) makes the count 0 and the machine idle, so seg_n shows the glyph for 0.
- R2: After an up press, the count rises by exactly one at each clock edge where tick_en is high, and it is unchanged at other edges.
- R3: A rising run that reaches 15 stops there. Later ticks leave the count at 15 until a new press.
- R4: After a down press, the count falls by exactly one at each clock edge where tick_en is high.
- R5: A falling run that reaches 0 stops there. Later ticks leave the count at 0 until a new press.
- R6: While the machine is idle, or in any cycle without a tick, the count does not change unless a load or reset occurs.
- R7: A button that stays high for many cycles acts only at its low-to-high transition. Keeping it high afterwards issues no further command.
- R8: A load press loads sw[3:0] into the count at the next edge, whatever the levels of the up and down buttons. The machine then returns to idle, so following ticks do not move the count.
- R9: When up and down rise in the same cycle with no load, up is taken.
- R10: An up or down press during a run reverses the direction at once. The cycle of the press itself never changes the count.
- R11: A press toward a limit the count already holds (up at 15, down at 0) leaves the count unchanged.
- R12: seg_n is active-low with seg_n[6] = segment a through seg_n[0] = segment g. Active-high patterns abcdefg: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011, A=1110111, b=0011111, C=1001110, d=0111101, E=1001111, F=1000111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle rate-tick enable |
| btn_up | input | 1 | Debounced up button level |
| btn_dn | input | 1 | Debounced down button level |
| btn_ld | input | 1 | Debounced load button level |
| sw | input | SW_W (16) | Switch bus; low 4 bits are loaded |
| count | output | 4 | Current digit value |
| seg_n | output | 7 | Active-low segments, bit 6 = a ... bit 0 = g |

## Verification
The corner cases are the two saturation points. There, a design that stops one step early or wraps around would show 14 or 0 instead of 15, or 1 or 15 instead of 0. Held buttons are kept high across a load and across a reversal. A level-sensitive input would restart a run and move the count while the machine should be idle. Load is driven together with both direction buttons, and up together with down, to expose a wrong priority. A press on the same edge as a tick must move nothing, and a mis-ordered chain would step the count on the turnaround cycle. A load sweep over all sixteen values checks every glyph, catching a swapped segment order or a missing inversion.

// File: rtl/hexcnt_pkg.sv
package hexcnt_pkg;

  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_DN   = 2'd2,
    ST_LOAD = 2'd3
  } cnt_state_e;

  // Active-high segment pattern, bit 6 = a ... bit 0 = g
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [DIGIT_W-1:0] d);
    logic [SEG_W-1:0] g;
    case (d)
      4'h0: g = 7'b1111110;
      4'h1: g = 7'b0110000;
      4'h2: g = 7'b1101101;
      4'h3: g = 7'b1111001;
      4'h4: g = 7'b0110011;
      4'h5: g = 7'b1011011;
      4'h6: g = 7'b1011111;
      4'h7: g = 7'b1110000;
      4'h8: g = 7'b1111111;
      4'h9: g = 7'b1111011;
      4'hA: g = 7'b1110111;
      4'hB: g = 7'b0011111;
      4'hC: g = 7'b1001110;
      4'hD: g = 7'b0111101;
      4'hE: g = 7'b1001111;
      default: g = 7'b1000111;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/btn_rise_det.sv
module btn_rise_det #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end

endmodule

// File: rtl/hexcnt_fsm.sv
module hexcnt_fsm
  import hexcnt_pkg::*;
#(
  parameter int SW_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               up_pulse,
  input  logic               dn_pulse,
  input  logic               ld_pulse,
  input  logic [SW_W-1:0]    sw,
  output cnt_state_e         state_o,
  output logic [DIGIT_W-1:0] count_o
);

  localparam logic [DIGIT_W-1:0] TOP      = '1;
  localparam logic [DIGIT_W-1:0] BOTTOM   = '0;
  localparam logic [DIGIT_W-1:0] ONE      = {{(DIGIT_W-1){1'b0}}, 1'b1};
  localparam logic [DIGIT_W-1:0] NEAR_TOP = {{(DIGIT_W-1){1'b1}}, 1'b0};

  cnt_state_e         state_q, state_d;
  logic [DIGIT_W-1:0] cnt_q, cnt_d;

  // state register
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= BOTTOM;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // next-state logic: load > up > down > run
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (ld_pulse) begin
      state_d = ST_LOAD;
      cnt_d   = sw[DIGIT_W-1:0];
    end else if (up_pulse) begin
      state_d = ST_UP;
    end else if (dn_pulse) begin
      state_d = ST_DN;
    end else begin
      unique case (state_q)
        ST_LOAD: state_d = ST_IDLE;
        ST_UP: begin
          if (tick_en) begin
            if (cnt_q == TOP) begin
              state_d = ST_IDLE;
            end else begin
              cnt_d = cnt_q + ONE;
              if (cnt_q == NEAR_TOP) state_d = ST_IDLE;
            end
          end
        end
        ST_DN: begin
          if (tick_en) begin
            if (cnt_q == BOTTOM) begin
              state_d = ST_IDLE;
            end else begin
              cnt_d = cnt_q - ONE;
              if (cnt_q == ONE) state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // output logic
  assign state_o = state_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/hex_seg_drv.sv
module hex_seg_drv
  import hexcnt_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [DIGIT_W-1:0] digit,
  output logic [SEG_W-1:0]   seg
);

  logic [SEG_W-1:0] lit;
  assign lit = hex_glyph(digit);

  if (ACTIVE_LOW) begin : g_low
    assign seg = ~lit;
  end else begin : g_high
    assign seg = lit;
  end

endmodule

// File: rtl/updown_hex_counter.sv
module updown_hex_counter
  import hexcnt_pkg::*;
#(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            btn_up,
  input  logic            btn_dn,
  input  logic            btn_ld,
  input  logic [SW_W-1:0] sw,
  output logic [3:0]      count,
  output logic [6:0]      seg_n
);

  localparam int NBTN = 3;

  logic [NBTN-1:0] btn_lvl, btn_rise;
  logic            up_pulse, dn_pulse, ld_pulse;
  cnt_state_e      state_q;

  assign btn_lvl  = {btn_ld, btn_dn, btn_up};
  assign up_pulse = btn_rise[0];
  assign dn_pulse = btn_rise[1];
  assign ld_pulse = btn_rise[2];

  btn_rise_det #(.N(NBTN)) u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (btn_lvl),
    .rise_o (btn_rise)
  );

  hexcnt_fsm #(.SW_W(SW_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .up_pulse (up_pulse),
    .dn_pulse (dn_pulse),
    .ld_pulse (ld_pulse),
    .sw       (sw),
    .state_o  (state_q),
    .count_o  (count)
  );

  hex_seg_drv #(.ACTIVE_LOW(1'b1)) u_seg (
    .digit (count),
    .seg   (seg_n)
  );

endmodule

// File: rtl/hexcnt_chk.sv
module hexcnt_chk
  import hexcnt_pkg::*;
#(
  parameter int SW_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            tick_en,
  input logic            btn_up,
  input logic            btn_dn,
  input logic            btn_ld,
  input logic [SW_W-1:0] sw,
  input logic [3:0]      count,
  input logic [6:0]      seg_n,
  input cnt_state_e      state_q,
  input logic            up_pulse,
  input logic            dn_pulse,
  input logic            ld_pulse
);

  logic no_press;
  assign no_press = !up_pulse && !dn_pulse && !ld_pulse;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count == 4'd0 && state_q == ST_IDLE));

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP && tick_en && no_press && count != 4'hF) |=> count == $past(count) + 4'd1);

  p_sat_up_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_UP && tick_en && no_press && count == 4'hF) |=> (count == 4'hF && state_q == ST_IDLE));

  p_step_dn_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DN && tick_en && no_press && count != 4'h0) |=> count == $past(count) - 4'd1);

  p_sat_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DN && tick_en && no_press && count == 4'h0) |=> (count == 4'h0 && state_q == ST_IDLE));

  p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !ld_pulse) |=> $stable(count));

  p_held_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && state_q == ST_IDLE && btn_up && $past(btn_up) && !btn_dn && !btn_ld)
      |=> state_q == ST_IDLE);

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    ld_pulse |=> (count == $past(sw[3:0]) && state_q == ST_LOAD));

  p_load_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD && no_press) |=> state_q == ST_IDLE);

  p_tie_r9: assert property (@(posedge clk) disable iff (rst)
    (up_pulse && dn_pulse && !ld_pulse) |=> state_q == ST_UP);

  p_press_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ((up_pulse || dn_pulse) && !ld_pulse) |=> $stable(count));

  always @(posedge clk) begin
    if (!rst) begin
      p_seg_lit_r12: assert (seg_n != 7'h7F);
    end
  end

endmodule

bind updown_hex_counter hexcnt_chk #(.SW_W(SW_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .btn_up   (btn_up),
  .btn_dn   (btn_dn),
  .btn_ld   (btn_ld),
  .sw       (sw),
  .count    (count),
  .seg_n    (seg_n),
  .state_q  (state_q),
  .up_pulse (up_pulse),
  .dn_pulse (dn_pulse),
  .ld_pulse (ld_pulse)
);

// File: tb/updown_hex_counter_bench.sv
module updown_hex_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SW_W       = 16;
  localparam int N_RANDOM   = 4000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            tick_en = 1'b0;
  logic            btn_up = 1'b0;
  logic            btn_dn = 1'b0;
  logic            btn_ld = 1'b0;
  logic [SW_W-1:0] sw = '0;
  logic [3:0]      count;
  logic [6:0]      seg_n;

  int checks = 0;
  int failures = 0;

  // reference model: 0 idle, 1 up, 2 down, 3 load
  int    m_st = 0;
  int    m_cnt = 0;
  bit    m_pu = 0, m_pd = 0, m_pl = 0;
  string m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  updown_hex_counter #(.SW_W(SW_W)) u_updown_hex_counter (
    .clk(clk), .rst(rst), .tick_en(tick_en), .btn_up(btn_up), .btn_dn(btn_dn),
    .btn_ld(btn_ld), .sw(sw), .count(count), .seg_n(seg_n)
  );

  function automatic logic [6:0] exp_seg(input int v);
    logic [6:0] on;
    case (v)
      0: on = 7'b1111110;  1: on = 7'b0110000;  2: on = 7'b1101101;  3: on = 7'b1111001;
      4: on = 7'b0110011;  5: on = 7'b1011011;  6: on = 7'b1011111;  7: on = 7'b1110000;
      8: on = 7'b1111111;  9: on = 7'b1111011; 10: on = 7'b1110111; 11: on = 7'b0011111;
      12: on = 7'b1001110; 13: on = 7'b0111101; 14: on = 7'b1001111; default: on = 7'b1000111;
    endcase
    return ~on;
  endfunction

  task automatic model_edge(input bit r, t, u, d, l, input logic [SW_W-1:0] s);
    bit up_r, dn_r, ld_r;
    if (r) begin
      m_st = 0; m_cnt = 0; m_pu = 0; m_pd = 0; m_pl = 0; m_tag = "R1";
      return;
    end
    up_r = u && !m_pu; dn_r = d && !m_pd; ld_r = l && !m_pl;
    m_tag = ((u && m_pu) || (d && m_pd) || (l && m_pl)) ? "R7" : "R6";
    if (ld_r) begin
      m_st = 3; m_cnt = int'(s[3:0]); m_tag = "R8";
    end else if (up_r) begin
      m_st = 1; m_tag = dn_r ? "R9" : (m_cnt == 15 ? "R11" : "R10");
    end else if (dn_r) begin
      m_st = 2; m_tag = (m_cnt == 0) ? "R11" : "R10";
    end else begin
      case (m_st)
        3: begin m_st = 0; m_tag = "R8"; end
        1: if (t) begin
             if (m_cnt == 15) begin m_st = 0; m_tag = "R3"; end
             else begin m_cnt++; m_tag = "R2"; if (m_cnt == 15) m_st = 0; end
           end
        2: if (t) begin
             if (m_cnt == 0) begin m_st = 0; m_tag = "R5"; end
             else begin m_cnt--; m_tag = "R4"; if (m_cnt == 0) m_st = 0; end
           end
        default: ;
      endcase
    end
    m_pu = u; m_pd = d; m_pl = l;
  endtask

  task automatic check_outputs();
    checks++;
    if (int'(count) != m_cnt) begin
      failures++;
      $display("FAIL %s count actual=%0d expected=%0d at %0t", m_tag, count, m_cnt, $time);
    end
    checks++;
    if (seg_n !== exp_seg(m_cnt)) begin
      failures++;
      $display("FAIL R12 seg_n actual=%b expected=%b at %0t", seg_n, exp_seg(m_cnt), $time);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit r, t, u, d, l, input logic [SW_W-1:0] s);
    rst = r; tick_en = t; btn_up = u; btn_dn = d; btn_ld = l; sw = s;
    @(posedge clk);
    model_edge(r, t, u, d, l, s);
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    @(negedge clk);
    // R1: reset
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, '0);
    // R6: ticks while idle
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, '0);
    // R8: load with both direction buttons rising
    step(0, 0, 1, 1, 1, 16'hABC7);
    // R7: direction buttons held, ticks move nothing
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 0, 16'h0000);
    step(0, 0, 0, 0, 0, '0);
    // R2/R3: up run to F then stays
    step(0, 0, 1, 0, 0, '0);
    for (int i = 0; i < 12; i++) step(0, 1, 1, 0, 0, '0);
    step(0, 0, 0, 0, 0, '0);
    // R9/R11: up and down together at F
    step(0, 0, 1, 1, 0, '0);
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, 0, '0);
    // R4 then R10: down run, reversal on a tick edge
    step(0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, '0);
    step(0, 1, 1, 1, 0, '0);
    step(0, 1, 1, 0, 0, '0);
    step(0, 0, 0, 0, 0, '0);
    // R5/R11: load 0 then down press
    step(0, 0, 0, 0, 1, 16'hFFF0);
    step(0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, '0);
    // R5: down run to 0 from 3
    step(0, 0, 0, 0, 1, 16'h0003);
    step(0, 0, 0, 1, 0, '0);
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, '0);
    // R12: every glyph via loads
    for (int v = 0; v < 16; v++) begin
      step(0, 0, 0, 0, 1, SW_W'(v) | 16'h5A50);
      step(0, 1, 0, 0, 0, '0);
    end
    // constrained random
    for (int i = 0; i < N_RANDOM; i++) begin
      bit r, t, u, d, l;
      r = ($urandom % 400) == 0;
      t = ($urandom % 3) == 0;
      u = (($urandom % 6) == 0) ? !btn_up : btn_up;
      d = (($urandom % 7) == 0) ? !btn_dn : btn_dn;
      l = (($urandom % 25) == 0) ? !btn_ld : (btn_ld && (($urandom % 2) == 0));
      step(r, t, u, d, l, SW_W'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule